// File: doc/BRIEF.md
# DMA Channel Control Registers

This block is the control side of one bus-master DMA channel. Software programs a start byte count, a start memory address and a start descriptor address, then writes a command word. Its two low bits pick an operation: idle, blast, abort or start. A start copies the three start values into working counters and clears the status flags. It also moves a two-state controller from `ST_OFF` to `ST_RUN`, and `ST_RUN` drives the DMA-enable output. An idle command takes the controller back to `ST_OFF`. An abort raises a one-cycle abort request. A blast is accepted and has no effect. Any other command leaves the state as it is.

While data moves, the attached storage-bus core reports each burst with a direction and a length. The block clips the length to the bytes that remain, then subtracts that amount from the working count and adds it to the working address. The granted length and the current working address go back to the memory side. When the core signals that the command has finished, the remaining count is forced to zero and the done flag is set. The status word is sticky. A live interrupt from the core is merged into it on every read. A mode input chooses how flags clear: write-one-to-clear, or cleared by the read itself.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the registers read as follows: index 0 (command) = 0, index 3 (working count) = 0, index 4 (working address) = 0xFFFFFFFF, index 7 (working descriptor) = 0xFFFFFFFD, index 5 (status) = 0. After reset `dma_en` = 0 and `abort_req` = 0.
- R2: Indices 0 (command), 1 (start count), 2 (start address) and 6 (start descriptor) store the whole written word and read it back. A write to index 3, 4 or 7 leaves that register unchanged.
- R3: A command write with bits [1:0] = 3 (start) has these effects from the next cycle: working count = start count, working address = start address, working descriptor = start descriptor, status bits [5:0] = 0, and `dma_en` = 1 (transition `ST_OFF`/`ST_RUN` to `ST_RUN`).
- R4: A command write with bits [1:0] = 0 (idle) makes `dma_en` = 0 from the next cycle (transition to `ST_OFF`).
- R5: A command write with bits [1:0] = 2 (abort) makes `abort_req` high for exactly the next cycle. A command write with bits [1:0] = 1 (blast) changes neither `dma_en`, `abort_req` nor the working registers.
- R6: A read of index 5 returns the stored status with the `core_irq` input ORed into bit 4.
- R7: With `clr_on_read` = 0, a write to index 5 clears each of status bit 1 (error), bit 2 (abort) and bit 3 (done) where the written bit is 1, and changes no other bit.
- R8: With `clr_on_read` = 1, writes to index 5 are ignored. A read of index 5 returns the current value, and bits 1, 2 and 3 are clear from the next cycle.
- R9: A burst (`xfer_req` = 1) whose `xfer_to_mem` differs from command bit 7 (1 = device to memory) is ignored and grants 0. Otherwise `xfer_grant` = min(`xfer_len`, working count). In the next cycle the working count is lower by the grant and the working address is higher by it, so a zero-length burst changes nothing. `xfer_addr` always shows the working address.
- R10: A `core_done` pulse sets the working count to 0 and status bit 3 (done) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| clr_on_read | input | 1 | Status clear mode: 0 write-one-to-clear, 1 clear on read |
| core_irq | input | 1 | Live interrupt level from the core |
| core_done | input | 1 | Command-complete pulse from the core |
| xfer_req | input | 1 | Burst request from the core |
| xfer_to_mem | input | 1 | Burst direction, 1 = device to memory |
| xfer_len | input | 32 | Requested burst length in bytes |
| xfer_grant | output | 32 | Clipped length granted for this burst |
| xfer_addr | output | 32 | Memory address of this burst (working address) |
| dma_en | output | 1 | DMA enable, high in `ST_RUN` |
| abort_req | output | 1 | One-cycle request to cancel the core's current command |

## Verification
The properties assume that two abort commands never arrive on consecutive cycles, so the one-cycle abort check stays meaningful. They also assume that `core_done` does not coincide with a start command. The stimulus spaces commands at least one idle cycle apart and issues completion pulses only between transfers, never together with a start. Bursts are random in length and direction, mostly matching the programmed direction, and each one is a single-cycle request.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_CMD   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SCNT  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_SADDR = 3'd2;
    localparam logic [IDX_W-1:0] IDX_WCNT  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_WADDR = 3'd4;
    localparam logic [IDX_W-1:0] IDX_STAT  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_SDESC = 3'd6;
    localparam logic [IDX_W-1:0] IDX_WDESC = 3'd7;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } op_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } chan_state_e;

    localparam int CMD_DIR_BIT  = 7;
    localparam int STAT_IRQ_BIT = 4;
    localparam int STAT_DONE_BIT = 3;
    localparam logic [5:0] STAT_STICKY_MASK = 6'b001110;
    localparam logic [5:0] STAT_ALL_MASK    = 6'b111111;
endpackage

// File: rtl/dma_cmd_fsm.sv
module dma_cmd_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic [1:0] op,
    output logic dma_en,
    output logic abort_req
);
    chan_state_e state_q, state_d;
    op_e op_sel;

    assign op_sel = op_e'(op);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cmd_wr) begin
            unique case (op_sel)
                OP_START: state_d = ST_RUN;
                OP_IDLE:  state_d = ST_OFF;
                default:  state_d = state_q;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  dma_en = 1'b1;
            default: dma_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) abort_req <= 1'b0;
        else        abort_req <= cmd_wr && (op_sel == OP_ABORT);
    end
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_cnt,
    input  logic [DW-1:0] ld_addr,
    input  logic [DW-1:0] ld_desc,
    input  logic          req,
    input  logic          req_dir,
    input  logic          cmd_dir,
    input  logic [DW-1:0] req_len,
    input  logic          core_done,
    output logic [DW-1:0] wcnt,
    output logic [DW-1:0] waddr,
    output logic [DW-1:0] wdesc,
    output logic [DW-1:0] grant
);
    localparam logic [DW-1:0] ADDR_RST = '1;
    localparam logic [DW-1:0] DESC_RST = ~DW'(2);

    logic hit;

    assign hit   = req && (req_dir == cmd_dir);
    assign grant = !hit ? '0 : ((req_len < wcnt) ? req_len : wcnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            waddr <= ADDR_RST;
            wdesc <= DESC_RST;
        end else if (load) begin
            wcnt  <= ld_cnt;
            waddr <= ld_addr;
            wdesc <= ld_desc;
        end else begin
            wcnt  <= core_done ? '0 : (wcnt - grant);
            waddr <= waddr + grant;
        end
    end
endmodule

// File: rtl/dma_status.sv
module dma_status
    import dma_chan_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          rd_mode,
    input  logic          done_set,
    output logic [DW-1:0] stat
);
    localparam logic [DW-1:0] STICKY = DW'(STAT_STICKY_MASK);
    localparam logic [DW-1:0] ALL    = DW'(STAT_ALL_MASK);

    logic [DW-1:0] stat_d;

    always_comb begin
        stat_d = stat;
        if (clr_all) begin
            stat_d = stat & ~ALL;
        end else begin
            if (wr && !rd_mode) stat_d = stat_d & ~(wdata & STICKY);
            if (rd && rd_mode)  stat_d = stat_d & ~STICKY;
            if (done_set)       stat_d[STAT_DONE_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_d;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          clr_on_read,
    input  logic          core_irq,
    input  logic          core_done,
    input  logic          xfer_req,
    input  logic          xfer_to_mem,
    input  logic [DW-1:0] xfer_len,
    output logic [DW-1:0] xfer_grant,
    output logic [DW-1:0] xfer_addr,
    output logic          dma_en,
    output logic          abort_req
);
    logic [DW-1:0] cmd_q, scnt_q, saddr_q, sdesc_q;
    logic [DW-1:0] wcnt, waddr, wdesc, stat;
    logic          cmd_wr, start_now;

    assign cmd_wr    = reg_wr && (reg_idx == IDX_CMD);
    assign start_now = cmd_wr && (reg_wdata[1:0] == OP_START);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            scnt_q  <= '0;
            saddr_q <= '0;
            sdesc_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_idx)
                IDX_CMD:   cmd_q   <= reg_wdata;
                IDX_SCNT:  scnt_q  <= reg_wdata;
                IDX_SADDR: saddr_q <= reg_wdata;
                IDX_SDESC: sdesc_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    dma_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .op        (reg_wdata[1:0]),
        .dma_en    (dma_en),
        .abort_req (abort_req)
    );

    dma_xfer_ctr #(.DW(DW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_now),
        .ld_cnt    (scnt_q),
        .ld_addr   (saddr_q),
        .ld_desc   (sdesc_q),
        .req       (xfer_req),
        .req_dir   (xfer_to_mem),
        .cmd_dir   (cmd_q[CMD_DIR_BIT]),
        .req_len   (xfer_len),
        .core_done (core_done),
        .wcnt      (wcnt),
        .waddr     (waddr),
        .wdesc     (wdesc),
        .grant     (xfer_grant)
    );

    dma_status #(.DW(DW)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (start_now),
        .wr       (reg_wr && (reg_idx == IDX_STAT)),
        .wdata    (reg_wdata),
        .rd       (reg_rd && (reg_idx == IDX_STAT)),
        .rd_mode  (clr_on_read),
        .done_set (core_done),
        .stat     (stat)
    );

    assign xfer_addr = waddr;

    always_comb begin
        unique case (reg_idx)
            IDX_CMD:   reg_rdata = cmd_q;
            IDX_SCNT:  reg_rdata = scnt_q;
            IDX_SADDR: reg_rdata = saddr_q;
            IDX_WCNT:  reg_rdata = wcnt;
            IDX_WADDR: reg_rdata = waddr;
            IDX_STAT:  reg_rdata = stat | (DW'(core_irq) << STAT_IRQ_BIT);
            IDX_SDESC: reg_rdata = sdesc_q;
            default:   reg_rdata = wdesc;
        endcase
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_idx,
    input logic [DW-1:0] reg_wdata,
    input logic          core_done,
    input logic          xfer_req,
    input logic          xfer_to_mem,
    input logic [DW-1:0] xfer_len,
    input logic [DW-1:0] xfer_grant,
    input logic          dma_en,
    input logic          abort_req,
    input logic [DW-1:0] cmd_q,
    input logic [DW-1:0] scnt_q,
    input logic [DW-1:0] wcnt
);
    logic cw;
    assign cw = reg_wr && (reg_idx == 3'd0);

    a_r3_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && reg_wdata[1:0] == 2'd3) |=> dma_en);

    a_r3_start_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && reg_wdata[1:0] == 2'd3) |=> (wcnt == $past(scnt_q)));

    a_r4_idle_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && reg_wdata[1:0] == 2'd0) |=> !dma_en);

    a_r5_abort_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && reg_wdata[1:0] == 2'd2) |=> abort_req);

    a_r5_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    a_r9_grant_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_grant <= xfer_len) && (xfer_grant <= wcnt));

    a_r9_wrong_dir_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && (xfer_to_mem != cmd_q[7])) |-> (xfer_grant == '0));

    a_r10_done_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !(cw && reg_wdata[1:0] == 2'd3)) |=> (wcnt == '0));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .core_done   (core_done),
    .xfer_req    (xfer_req),
    .xfer_to_mem (xfer_to_mem),
    .xfer_len    (xfer_len),
    .xfer_grant  (xfer_grant),
    .dma_en      (dma_en),
    .abort_req   (abort_req),
    .cmd_q       (cmd_q),
    .scnt_q      (scnt_q),
    .wcnt        (wcnt)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        clr_on_read = 1'b0, core_irq = 1'b0, core_done = 1'b0;
    logic        xfer_req = 1'b0, xfer_to_mem = 1'b0;
    logic [31:0] xfer_len = '0, xfer_grant, xfer_addr;
    logic        dma_en, abort_req;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_cnt, m_addr;
    logic        m_dir;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_on_read(clr_on_read), .core_irq(core_irq), .core_done(core_done),
        .xfer_req(xfer_req), .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len),
        .xfer_grant(xfer_grant), .xfer_addr(xfer_addr),
        .dma_en(dma_en), .abort_req(abort_req)
    );

    function automatic logic [31:0] exp_grant(input logic dir, input logic [31:0] len,
                                               input logic [31:0] cnt, input logic cdir);
        if (dir != cdir) return 32'd0;
        return (len < cnt) ? len : cnt;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 chk(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
        m_cnt = 32'd0;
    endtask

    task automatic burst(input logic dir, input logic [31:0] len);
        logic [31:0] g;
        @(negedge clk);
        xfer_req = 1'b1; xfer_to_mem = dir; xfer_len = len;
        g = exp_grant(dir, len, m_cnt, m_dir);
        #1 chk("R9 grant", xfer_grant, g);
        chk("R9 addr out", xfer_addr, m_addr);
        @(negedge clk);
        xfer_req = 1'b0;
        m_cnt  = m_cnt - g;
        m_addr = m_addr + g;
    endtask

    task automatic start(input logic dir, input logic [31:0] c, input logic [31:0] a,
                         input logic [31:0] d);
        wr(3'd1, c); wr(3'd2, a); wr(3'd6, d);
        wr(3'd0, {24'd0, dir, 5'd0, 2'd3});
        m_cnt = c; m_addr = a; m_dir = dir;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 cmd");
        rd(3'd3, 32'h0, "R1 wcnt");
        rd(3'd4, 32'hFFFF_FFFF, "R1 waddr");
        rd(3'd7, 32'hFFFF_FFFD, "R1 wdesc");
        rd(3'd5, 32'h0, "R1 status");
        chk("R1 dma_en", {31'd0, dma_en}, 32'd0);
        chk("R1 abort_req", {31'd0, abort_req}, 32'd0);

        // R2 writable and ignored indices
        wr(3'd1, 32'h1234_5678); rd(3'd1, 32'h1234_5678, "R2 scnt");
        wr(3'd2, 32'hCAFE_0000); rd(3'd2, 32'hCAFE_0000, "R2 saddr");
        wr(3'd6, 32'h0000_BEE0); rd(3'd6, 32'h0000_BEE0, "R2 sdesc");
        wr(3'd3, 32'h5555_5555); rd(3'd3, 32'h0, "R2 wcnt ignored");
        wr(3'd4, 32'h5555_5555); rd(3'd4, 32'hFFFF_FFFF, "R2 waddr ignored");
        wr(3'd7, 32'h5555_5555); rd(3'd7, 32'hFFFF_FFFD, "R2 wdesc ignored");

        // R3 start
        start(1'b1, 32'd300, 32'h0001_0000, 32'h0002_0040);
        chk("R3 dma_en", {31'd0, dma_en}, 32'd1);
        rd(3'd0, 32'h0000_0083, "R2 cmd readback");
        rd(3'd3, 32'd300, "R3 wcnt");
        rd(3'd4, 32'h0001_0000, "R3 waddr");
        rd(3'd7, 32'h0002_0040, "R3 wdesc");

        // R9 directed bursts
        burst(1'b1, 32'd0);
        burst(1'b1, 32'd100);
        burst(1'b0, 32'd50);
        burst(1'b1, 32'd500);
        rd(3'd3, m_cnt, "R9 wcnt");
        rd(3'd4, m_addr, "R9 waddr");

        // R5 blast then abort
        wr(3'd0, 32'h0000_0081);
        chk("R5 blast keeps enable", {31'd0, dma_en}, 32'd1);
        chk("R5 blast no abort", {31'd0, abort_req}, 32'd0);
        rd(3'd4, m_addr, "R5 blast waddr");
        wr(3'd0, 32'h0000_0082);
        chk("R5 abort pulse", {31'd0, abort_req}, 32'd1);
        @(negedge clk);
        chk("R5 abort one cycle", {31'd0, abort_req}, 32'd0);

        // R10, R6, R7
        start(1'b0, 32'd40, 32'h100, 32'h0);
        done_pulse();
        rd(3'd3, 32'd0, "R10 wcnt zero");
        rd(3'd5, 32'h08, "R10 done bit");
        core_irq = 1'b1;
        rd(3'd5, 32'h18, "R6 live irq");
        core_irq = 1'b0;
        wr(3'd5, 32'h0000_0030);
        rd(3'd5, 32'h08, "R7 unmasked bits");
        wr(3'd5, 32'h0000_0008);
        rd(3'd5, 32'h00, "R7 w1c done");

        // R8 clear on read
        done_pulse();
        clr_on_read = 1'b1;
        wr(3'd5, 32'h0000_0008);
        rd(3'd5, 32'h08, "R8 write ignored");
        rd(3'd5, 32'h00, "R8 read cleared");
        clr_on_read = 1'b0;

        // R3 start clears status
        done_pulse();
        start(1'b0, 32'd10, 32'h0, 32'h0);
        rd(3'd5, 32'h00, "R3 status cleared");

        // R4 idle
        wr(3'd0, 32'h0000_0000);
        chk("R4 dma_en dropped", {31'd0, dma_en}, 32'd0);

        // R9 random bursts
        for (int r = 0; r < 6; r++) begin
            logic dir;
            dir = 1'($urandom % 2);
            start(dir, ($urandom % 3000) + 1, $urandom, $urandom);
            for (int k = 0; k < 40; k++) begin
                logic bd;
                bd = (($urandom % 4) == 0) ? ~dir : dir;
                burst(bd, $urandom % 257);
            end
            rd(3'd3, m_cnt, "R9 random wcnt");
            rd(3'd4, m_addr, "R9 random waddr");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule